// File: doc/BRIEF.md
# Multi-channel shared-buffer FIFO

This block is a peripheral-side FIFO bank in which several logical channels share one physical storage array. Each channel owns a programmable region of that array, described by a base address and a size in words. Within its region the channel behaves as a ring buffer: the DMA side pushes words in through a channel-addressed write port, and the audio side pulls them out through a channel-addressed read port.

The block sends no threshold requests and no occupancy count toward the DMA side. Its only feedback there is one pulse per accepted word on a per-channel event line, one line for writes and one for reads. The DMA engine keeps its own credit counter from these pulses. Full, empty, sticky overflow and underflow flags, and a configuration-error flag are also provided for local observation.

Out of reset, the array is split evenly: channel c starts at c*DEPTH/NUM_CH with DEPTH/NUM_CH words. A region may be rewritten only while the channel's enable input is low.

Top module: `shfifo_top`

## Requirements
- R1: After reset every channel is empty and not full, no event line is high, every overflow and underflow flag is 0, and cfgErr is 0.
- R2: A region write (cfgWe with cfgCh, cfgBase, cfgSize) takes effect only while chEnable[cfgCh] is 0. It empties that channel and clears its overflow and underflow flags. While the channel is enabled, the write changes nothing.
- R3: A write to an enabled full channel is dropped with no event and sets that channel's overflow flag. The flag stays set until reset or an accepted region write.
- R4: A read from an enabled empty channel is dropped with no event and sets that channel's underflow flag. The flag stays set until reset or an accepted region write.
- R5: Each accepted write sets wrEvt bit wrCh high for exactly the one cycle after the accepting clock edge. Each accepted read does the same on rdEvt bit rdCh. No other bit of either vector is high.
- R6: Words come out of a channel in the order they went in, and the pointers wrap from base+size-1 back to base. rdData shows the word in the cycle after an accepted read, the same cycle as the read event, and holds it otherwise.
- R7: A read and a write to the same channel in one cycle are both accepted whenever the read is. This holds even when the channel is full. The occupancy does not change.
- R8: cfgErr is 1 while the sum of all region sizes exceeds DEPTH, or while any base+size exceeds DEPTH. While it is 1, every access is ignored: there are no events and no flag or occupancy changes.
- R9: An access to a channel whose chEnable bit is 0 is ignored: there is no event, and its occupancy and flags do not change.
- R10: full[c] is 1 exactly when the occupancy of channel c equals its size, and empty[c] is 1 exactly when the occupancy is 0. Channels fill and drain independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chEnable | input | NUM_CH | Per-channel enable |
| cfgWe | input | 1 | Region write strobe |
| cfgCh | input | log2(NUM_CH) | Channel whose region is written |
| cfgBase | input | log2(DEPTH) | New region base address |
| cfgSize | input | log2(DEPTH)+1 | New region size in words |
| wrValid | input | 1 | Write request from the DMA side |
| wrCh | input | log2(NUM_CH) | Write channel |
| wrData | input | WIDTH | Write word |
| rdValid | input | 1 | Read request from the audio side |
| rdCh | input | log2(NUM_CH) | Read channel |
| rdData | output | WIDTH | Read word, one cycle after acceptance |
| wrEvt | output | NUM_CH | Per-channel accepted-write pulse |
| rdEvt | output | NUM_CH | Per-channel accepted-read pulse |
| full | output | NUM_CH | Channel region full |
| empty | output | NUM_CH | Channel region empty |
| ovfFlag | output | NUM_CH | Sticky write-overflow flag |
| udfFlag | output | NUM_CH | Sticky read-underflow flag |
| cfgErr | output | 1 | Region configuration invalid |

## Verification
The bench builds the block with NUM_CH=4, DEPTH=16 and WIDTH=8, so each channel starts with a four-word region. At that size, filling a channel, wrapping its pointers and overflowing it takes only a handful of cycles. The small depth also makes oversubscription easy to set up: one eight-word region, or a region placed near the top of the array, is enough to push the total past the array, so the configuration-error path is exercised without long setup.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic wrGo;   // accepted write: store word, pulse write event
    logic rdGo;   // accepted read: load word, pulse read event
  } memStb_t;
endpackage

// File: rtl/shfifo_ctrl.sv
module shfifo_ctrl
  import shfifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = $clog2(NUM_CH),
  localparam int SW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic              cfgWe,
  input  logic [CHW-1:0]    cfgCh,
  input  logic [AW-1:0]     cfgBase,
  input  logic [SW-1:0]     cfgSize,
  input  logic              wrValid,
  input  logic [CHW-1:0]    wrCh,
  input  logic              rdValid,
  input  logic [CHW-1:0]    rdCh,
  output memStb_t           stb,
  output logic [AW-1:0]     wAddr,
  output logic [AW-1:0]     rAddr,
  output logic [NUM_CH-1:0] full,
  output logic [NUM_CH-1:0] empty,
  output logic [NUM_CH-1:0] ovfFlag,
  output logic [NUM_CH-1:0] udfFlag,
  output logic              cfgErr
);
  localparam int SUMW    = SW + CHW + 1;
  localparam int REGION0 = DEPTH / NUM_CH;

  logic [AW-1:0] baseR [NUM_CH];
  logic [SW-1:0] sizeR [NUM_CH];
  logic [AW-1:0] wPtrR [NUM_CH];
  logic [AW-1:0] rPtrR [NUM_CH];
  logic [SW-1:0] cntR  [NUM_CH];
  logic [NUM_CH-1:0] ovfR, udfR;

  // Next ring position inside a region.
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p,
                                         input logic [AW-1:0] b,
                                         input logic [SW-1:0] s);
    logic [SW-1:0] last;
    last = SW'(b) + s - SW'(1);
    if (SW'(p) == last) return b;
    return p + AW'(1);
  endfunction

  // Region sanity: total capacity and per-region upper bound.
  logic [SUMW-1:0] sizeSum;
  logic            boundBad;
  always_comb begin
    sizeSum  = '0;
    boundBad = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      sizeSum = sizeSum + SUMW'(sizeR[c]);
      if (SUMW'(baseR[c]) + SUMW'(sizeR[c]) > SUMW'(DEPTH)) boundBad = 1'b1;
    end
  end
  assign cfgErr = boundBad || (sizeSum > SUMW'(DEPTH));

  logic [NUM_CH-1:0] active;
  assign active = chEnable & {NUM_CH{~cfgErr}};

  logic cfgTake;
  assign cfgTake = cfgWe && !chEnable[cfgCh];

  // Acceptance decisions.
  logic wrHit, rdHit, wrOk, rdOk, sameCh;
  always_comb begin
    wrHit  = wrValid && active[wrCh];
    rdHit  = rdValid && active[rdCh];
    sameCh = (wrCh == rdCh);
    rdOk   = rdHit && !empty[rdCh];
    wrOk   = wrHit && (!full[wrCh] || (rdOk && sameCh));
  end

  assign stb.wrGo = wrOk;
  assign stb.rdGo = rdOk;
  assign wAddr    = wPtrR[wrCh];
  assign rAddr    = rPtrR[rdCh];
  assign ovfFlag  = ovfR;
  assign udfFlag  = udfR;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic selW, selR, inc, dec, cfgMe;
    assign selW  = (wrCh == CHW'(c));
    assign selR  = (rdCh == CHW'(c));
    assign inc   = wrOk && selW;
    assign dec   = rdOk && selR;
    assign cfgMe = cfgTake && (cfgCh == CHW'(c));
    assign full[c]  = (cntR[c] == sizeR[c]);
    assign empty[c] = (cntR[c] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR[c] <= AW'(c * REGION0);
        sizeR[c] <= SW'(REGION0);
        wPtrR[c] <= AW'(c * REGION0);
        rPtrR[c] <= AW'(c * REGION0);
        cntR[c]  <= '0;
        ovfR[c]  <= 1'b0;
        udfR[c]  <= 1'b0;
      end else if (cfgMe) begin
        baseR[c] <= cfgBase;
        sizeR[c] <= cfgSize;
        wPtrR[c] <= cfgBase;
        rPtrR[c] <= cfgBase;
        cntR[c]  <= '0;
        ovfR[c]  <= 1'b0;
        udfR[c]  <= 1'b0;
      end else begin
        if (inc) wPtrR[c] <= bump(wPtrR[c], baseR[c], sizeR[c]);
        if (dec) rPtrR[c] <= bump(rPtrR[c], baseR[c], sizeR[c]);
        cntR[c] <= cntR[c] + SW'(inc) - SW'(dec);
        if (wrHit && !wrOk && selW) ovfR[c] <= 1'b1;
        if (rdHit && !rdOk && selR) udfR[c] <= 1'b1;
      end
    end

    // R10: occupancy never exceeds the region size
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
      cntR[c] <= sizeR[c]);
    // R7: simultaneous accepted read and write leave occupancy unchanged
    p_both_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
      (inc && dec) |=> $stable(cntR[c]));
    // R9: a disabled channel keeps its occupancy unless reprogrammed
    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (!chEnable[c] && !cfgMe) |=> $stable(cntR[c]));
    // R3: overflow flag is sticky until region rewrite
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[c] && !cfgMe) |=> ovfFlag[c]);
    // R4: underflow flag is sticky until region rewrite
    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (udfFlag[c] && !cfgMe) |=> udfFlag[c]);
  end
endmodule

// File: rtl/shfifo_dpath.sv
module shfifo_dpath
  import shfifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStb_t           stb,
  input  logic [AW-1:0]     wAddr,
  input  logic [AW-1:0]     rAddr,
  input  logic [CHW-1:0]    wrCh,
  input  logic [CHW-1:0]    rdCh,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  output logic [NUM_CH-1:0] wrEvt,
  output logic [NUM_CH-1:0] rdEvt
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrGo) store[wAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      wrEvt  <= '0;
      rdEvt  <= '0;
    end else begin
      wrEvt <= stb.wrGo ? (NUM_CH'(1) << wrCh) : '0;
      rdEvt <= stb.rdGo ? (NUM_CH'(1) << rdCh) : '0;
      if (stb.rdGo) rdData <= store[rAddr];
    end
  end

  // R5: at most one write and one read event line per cycle
  p_evt_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEvt) && $onehot0(rdEvt));
  // R5: no event without an accepted access the cycle before
  p_no_spurious_evt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrGo && !stb.rdGo) |=> (wrEvt == '0 && rdEvt == '0));
  // R6: read data holds when nothing is read
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdGo |=> $stable(rdData));
endmodule

// File: rtl/shfifo_top.sv
module shfifo_top
  import shfifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic              cfgWe,
  input  logic [CHW-1:0]    cfgCh,
  input  logic [AW-1:0]     cfgBase,
  input  logic [AW:0]       cfgSize,
  input  logic              wrValid,
  input  logic [CHW-1:0]    wrCh,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              rdValid,
  input  logic [CHW-1:0]    rdCh,
  output logic [WIDTH-1:0]  rdData,
  output logic [NUM_CH-1:0] wrEvt,
  output logic [NUM_CH-1:0] rdEvt,
  output logic [NUM_CH-1:0] full,
  output logic [NUM_CH-1:0] empty,
  output logic [NUM_CH-1:0] ovfFlag,
  output logic [NUM_CH-1:0] udfFlag,
  output logic              cfgErr
);
  memStb_t       stb;
  logic [AW-1:0] wAddr, rAddr;

  shfifo_ctrl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .chEnable(chEnable),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .wrValid(wrValid), .wrCh(wrCh), .rdValid(rdValid), .rdCh(rdCh),
    .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .full(full), .empty(empty), .ovfFlag(ovfFlag), .udfFlag(udfFlag),
    .cfgErr(cfgErr)
  );

  shfifo_dpath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .wrCh(wrCh), .rdCh(rdCh), .wrData(wrData),
    .rdData(rdData), .wrEvt(wrEvt), .rdEvt(rdEvt)
  );
endmodule

// File: tb/sim_shfifo_top.sv
`timescale 1ns/1ps
module sim_shfifo_top;
  localparam int NCH = 4;
  localparam int DEP = 16;
  localparam int WD  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] chEnable;
  logic cfgWe;
  logic [1:0] cfgCh;
  logic [3:0] cfgBase;
  logic [4:0] cfgSize;
  logic wrValid, rdValid;
  logic [1:0] wrCh, rdCh;
  logic [WD-1:0] wrData, rdData;
  logic [NCH-1:0] wrEvt, rdEvt, full, empty, ovfFlag, udfFlag;
  logic cfgErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shfifo_top #(.NUM_CH(NCH), .DEPTH(DEP), .WIDTH(WD)) u0 (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgBase(cfgBase), .cfgSize(cfgSize), .wrValid(wrValid), .wrCh(wrCh),
    .wrData(wrData), .rdValid(rdValid), .rdCh(rdCh), .rdData(rdData),
    .wrEvt(wrEvt), .rdEvt(rdEvt), .full(full), .empty(empty),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of traffic at a falling edge, sample at the next falling edge.
  task automatic cyc(input logic wv, input logic [1:0] wc, input logic [WD-1:0] wd,
                     input logic rv, input logic [1:0] rc);
    wrValid = wv; wrCh = wc; wrData = wd; rdValid = rv; rdCh = rc;
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0; rdValid = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [3:0] b, input logic [4:0] s);
    cfgWe = 1'b1; cfgCh = ch; cfgBase = b; cfgSize = s;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // {isRead, ch[1:0], data[7:0], expectEvent, expectData[7:0]}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h11, 1'b1, 8'h00},
    {1'b0, 2'd0, 8'h22, 1'b1, 8'h00},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h11},
    {1'b0, 2'd0, 8'h33, 1'b1, 8'h00},
    {1'b0, 2'd0, 8'h44, 1'b1, 8'h00},
    {1'b0, 2'd0, 8'h55, 1'b1, 8'h00},
    {1'b0, 2'd0, 8'h66, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'hA1, 1'b1, 8'h00},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h22},
    {1'b1, 2'd1, 8'h00, 1'b1, 8'hA1},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h33},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h44},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h55},
    {1'b1, 2'd0, 8'h00, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'hB2, 1'b1, 8'h00},
    {1'b1, 2'd1, 8'h00, 1'b1, 8'hB2}
  };

  initial begin
    #800000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    chEnable = '1; cfgWe = 1'b0; cfgCh = '0; cfgBase = '0; cfgSize = '0;
    wrValid = 1'b0; rdValid = 1'b0; wrCh = '0; rdCh = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 empty", 32'(empty), 32'hF);
    chk("R1 full", 32'(full), 32'h0);
    chk("R1 events", 32'({wrEvt, rdEvt}), 32'h0);
    chk("R1 flags", 32'({ovfFlag, udfFlag, cfgErr}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 R6 R3 R4: vector walk over channels 0 and 1, wrapping channel 0
    for (int i = 0; i < NV; i++) begin
      logic isRd;
      logic [1:0] ch;
      logic [NCH-1:0] expEv;
      isRd = VEC[i][19];
      ch   = VEC[i][18:17];
      expEv = VEC[i][8] ? (NCH'(1) << ch) : '0;
      if (isRd) begin
        cyc(1'b0, 2'd0, 8'h00, 1'b1, ch);
        chk("R5 rd event", 32'({wrEvt, rdEvt}), 32'({4'h0, expEv}));
        if (VEC[i][8]) chk("R6 rd data", 32'(rdData), 32'(VEC[i][7:0]));
      end else begin
        cyc(1'b1, ch, VEC[i][16:9], 1'b0, 2'd0);
        chk("R5 wr event", 32'({wrEvt, rdEvt}), 32'({expEv, 4'h0}));
      end
    end
    chk("R3 ovf sticky", 32'(ovfFlag), 32'h1);
    chk("R4 udf sticky", 32'(udfFlag), 32'h1);

    // R10 R7: fill channel 2, then read and write it together while full
    for (int k = 0; k < 4; k++) cyc(1'b1, 2'd2, 8'hC0 + 8'(k), 1'b0, 2'd0);
    chk("R10 full", 32'(full), 32'h4);
    chk("R10 empty", 32'(empty), 32'hB);
    cyc(1'b1, 2'd2, 8'hC4, 1'b1, 2'd2);
    chk("R7 both events", 32'({wrEvt, rdEvt}), 32'h44);
    chk("R7 data", 32'(rdData), 32'hC0);
    chk("R7 still full", 32'(full[2]), 32'h1);
    chk("R7 no ovf", 32'(ovfFlag[2]), 32'h0);

    // R9: disabled channel ignores traffic
    chEnable = 4'b1011;
    cyc(1'b1, 2'd2, 8'hEE, 1'b0, 2'd0);
    chk("R9 no wr event", 32'(wrEvt), 32'h0);
    chk("R9 no ovf", 32'(ovfFlag[2]), 32'h0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 2'd2);
    chk("R9 no rd event", 32'(rdEvt), 32'h0);
    chk("R9 still full", 32'(full[2]), 32'h1);
    chEnable = 4'b1111;
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 2'd2);
    chk("R6 order after R9", 32'(rdData), 32'hC1);

    // R2: region rewrite while disabled, ignored while enabled
    chEnable = 4'b0111;
    cfg(2'd3, 4'd12, 5'd2);
    chEnable = 4'b1111;
    cyc(1'b1, 2'd3, 8'hD0, 1'b0, 2'd0);
    cyc(1'b1, 2'd3, 8'hD1, 1'b0, 2'd0);
    chk("R2 new size full", 32'(full[3]), 32'h1);
    cfg(2'd3, 4'd12, 5'd4);
    chk("R2 ignored when enabled", 32'({full[3], empty[3]}), 32'h2);
    chEnable = 4'b1110;
    cfg(2'd0, 4'd0, 5'd4);
    chk("R2 clears flags", 32'({ovfFlag[0], udfFlag[0]}), 32'h0);
    chk("R2 empties", 32'(empty[0]), 32'h1);
    chEnable = 4'b1111;

    // R8: oversubscription (sum 18 > 16)
    chEnable = 4'b1101;
    cfg(2'd1, 4'd4, 5'd8);
    chk("R8 sum error", 32'(cfgErr), 32'h1);
    chEnable = 4'b1111;
    cyc(1'b1, 2'd0, 8'h77, 1'b0, 2'd0);
    chk("R8 no event", 32'(wrEvt), 32'h0);
    chk("R8 unchanged", 32'({empty[0], ovfFlag[0]}), 32'h2);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 2'd0);
    chk("R8 no udf", 32'({rdEvt[0], udfFlag[0]}), 32'h0);
    // R8: region running past the array top
    chEnable = 4'b1101;
    cfg(2'd1, 4'd14, 5'd4);
    chk("R8 bound error", 32'(cfgErr), 32'h1);
    cfg(2'd1, 4'd4, 5'd4);
    chk("R8 cleared", 32'(cfgErr), 32'h0);
    chEnable = 4'b1111;
    cyc(1'b1, 2'd0, 8'h78, 1'b0, 2'd0);
    chk("R8 traffic resumes", 32'(wrEvt), 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule